// File: doc/BRIEF.md
# PHY Interface Control Register

This block holds one 8-bit configuration byte for a USB transceiver and turns it into the control lines that the rest of the PHY uses. The link reaches the byte through a small register port: an address, a write strobe, write data and combinational read data. Three neighbouring addresses give three ways to write the byte. The first replaces it. The second ORs the written data into it. The third clears every bit that is 1 in the written data. A read at any of the three addresses returns the stored byte.

From the stored byte the block produces several outputs: the selects for the 3-pin and 6-pin full/low-speed serial modes, a clock power enable, a fault indicator with a programmable polarity, and the enables for the STP pull-up and the DATA pull-downs. The PHY tells the block when it leaves a serial mode, and the block then clears the matching mode bit by itself.

The field positions are fixed, because the link software decodes them. Bit 7 disables interface protection. Bit 6 is indicator pass-through. Bit 5 inverts the fault indicator. Bit 3 is the active-low clock suspend. Bit 1 selects 3-pin serial mode and bit 0 selects 6-pin serial mode. Bits 4 and 2 are reserved.

Top module: `phy_ifctl`

## Requirements
- R1: After reset the stored byte is 0x00. In that state both serial selects are 0, clk_power_en is 1, stp_pullup_en is 1, and fault_ind_out follows fault_in.
- R2: A write at address 0x07 replaces the stored byte with reg_wdata. Reserved bits are excluded from this.
- R3: A write at address 0x08 ORs reg_wdata into the stored byte.
- R4: A write at address 0x09 clears each stored bit whose reg_wdata bit is 1 and leaves the other bits unchanged.
- R5: With reg_addr at 0x07, 0x08 or 0x09, reg_rdata shows the stored byte. At any other address reg_rdata is 0x00, and a write there leaves the stored byte unchanged.
- R6: Bits 4 and 2 always read 0, whatever is written, set or cleared.
- R7: A one-cycle pulse on exit_3pin clears bit 1, and a pulse on exit_6pin clears bit 0. If a write in the same cycle would set that bit, the clear still takes effect.
- R8: serial6_en equals bit 0. serial3_en equals bit 1 only while bit 0 is 0, so the 6-pin mode takes priority.
- R9: fault_ind_out equals fault_in when bit 5 is 0, and the inverse of fault_in when bit 5 is 1.
- R10: While a serial mode bit (bit 0 or bit 1) is 1 and suspend_n is 1, clk_power_en equals bit 3. In every other case clk_power_en is 1 and bit 3 has no effect.
- R11: While bit 7 is 0, stp_pullup_en is 1 and data_pulldown_en is 1 exactly when stp_in is high and stp_expected is low. While bit 7 is 1, both enables are 0.
- R12: Bit 6 is stored and read back, and it drives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register access address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current address |
| exit_3pin | input | 1 | Pulse: PHY has left 3-pin serial mode |
| exit_6pin | input | 1 | Pulse: PHY has left 6-pin serial mode |
| suspend_n | input | 1 | PHY suspend control, 1 when not suspended |
| fault_in | input | 1 | Raw fault indicator input |
| fault_ind_out | output | 1 | Fault indicator after the polarity select |
| stp_in | input | 1 | Observed STP line level |
| stp_expected | input | 1 | High while an STP assertion by the link is legitimate |
| serial3_en | output | 1 | 3-pin serial mode active |
| serial6_en | output | 1 | 6-pin serial mode active |
| clk_power_en | output | 1 | Keep the internal clock powered |
| stp_pullup_en | output | 1 | Weak pull-up on STP enabled |
| data_pulldown_en | output | 1 | Weak pull-downs on DATA enabled |

## Verification
The hardest case to reach is a link write that lands in the same cycle as a mode-exit pulse. The write and the pulse must share one clock edge, and the write must be one that would set the bit the pulse clears. The bench raises the write strobe and the exit pulse on the same falling edge, holds them for one cycle, and then reads the byte back to confirm that the self-clear won. Clock qualification is checked by stepping suspend_n and the mode bits separately. This shows that bit 3 matters only when both conditions hold.

// File: rtl/ifctl_pkg.sv
package ifctl_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_ALIAS  = 3;
    localparam int B_PROT_DIS = 7;
    localparam int B_PASS     = 6;
    localparam int B_COMPL    = 5;
    localparam int B_CLKSUS_N = 3;
    localparam int B_SER3     = 1;
    localparam int B_SER6     = 0;
    localparam logic [REG_W-1:0] RSVD_MASK = 8'h14;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_SET   = 2'd2,
        ACC_CLEAR = 2'd3
    } acc_e;

    typedef struct packed {
        logic [REG_W-1:0] ctl;
    } store_t;
endpackage

// File: rtl/ifctl_decode.sv
module ifctl_decode
    import ifctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 7
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    output acc_e              acc,
    output logic              rd_hit
);
    logic [NUM_ALIAS-1:0] hit;

    for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
        assign hit[k] = (reg_addr == ADDR_W'(BASE_ADDR + k));
    end

    assign rd_hit = |hit;

    always_comb begin
        acc = ACC_NONE;
        if (reg_we) begin
            if (hit[0])      acc = ACC_WRITE;
            else if (hit[1]) acc = ACC_SET;
            else if (hit[2]) acc = ACC_CLEAR;
        end
    end
endmodule

// File: rtl/ifctl_store.sv
module ifctl_store
    import ifctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             acc,
    input  logic [REG_W-1:0] wdata,
    input  logic             exit_3pin,
    input  logic             exit_6pin,
    output logic [REG_W-1:0] ctl
);
    store_t st_d, st_q;
    logic [REG_W-1:0] merged;

    always_comb begin
        st_d   = st_q;
        merged = st_q.ctl;
        unique case (acc)
            ACC_WRITE: merged = wdata;
            ACC_SET:   merged = st_q.ctl | wdata;
            ACC_CLEAR: merged = st_q.ctl & ~wdata;
            default:   merged = st_q.ctl;
        endcase
        merged = merged & ~RSVD_MASK;
        if (exit_3pin) merged[B_SER3] = 1'b0;
        if (exit_6pin) merged[B_SER6] = 1'b0;
        st_d.ctl = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;
endmodule

// File: rtl/ifctl_drive.sv
module ifctl_drive (
    input  logic prot_dis,
    input  logic compl,
    input  logic clksus_n,
    input  logic ser3,
    input  logic ser6,
    input  logic suspend_n,
    input  logic fault_in,
    input  logic stp_in,
    input  logic stp_expected,
    output logic fault_ind_out,
    output logic serial3_en,
    output logic serial6_en,
    output logic clk_power_en,
    output logic stp_pullup_en,
    output logic data_pulldown_en
);
    logic serial_any;

    always_comb begin
        serial6_en       = ser6;
        serial3_en       = ser3 & ~ser6;
        serial_any       = ser3 | ser6;
        clk_power_en     = (serial_any && suspend_n) ? clksus_n : 1'b1;
        fault_ind_out    = fault_in ^ compl;
        stp_pullup_en    = ~prot_dis;
        data_pulldown_en = ~prot_dis & stp_in & ~stp_expected;
    end
endmodule

// File: rtl/phy_ifctl.sv
module phy_ifctl
    import ifctl_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              exit_3pin,
    input  logic              exit_6pin,
    input  logic              suspend_n,
    input  logic              fault_in,
    output logic              fault_ind_out,
    input  logic              stp_in,
    input  logic              stp_expected,
    output logic              serial3_en,
    output logic              serial6_en,
    output logic              clk_power_en,
    output logic              stp_pullup_en,
    output logic              data_pulldown_en
);
    acc_e             acc;
    logic             rd_hit;
    logic [REG_W-1:0] ctl_q;

    ifctl_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .acc      (acc),
        .rd_hit   (rd_hit)
    );

    ifctl_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .wdata     (reg_wdata),
        .exit_3pin (exit_3pin),
        .exit_6pin (exit_6pin),
        .ctl       (ctl_q)
    );

    ifctl_drive u_drv (
        .prot_dis         (ctl_q[B_PROT_DIS]),
        .compl            (ctl_q[B_COMPL]),
        .clksus_n         (ctl_q[B_CLKSUS_N]),
        .ser3             (ctl_q[B_SER3]),
        .ser6             (ctl_q[B_SER6]),
        .suspend_n        (suspend_n),
        .fault_in         (fault_in),
        .stp_in           (stp_in),
        .stp_expected     (stp_expected),
        .fault_ind_out    (fault_ind_out),
        .serial3_en       (serial3_en),
        .serial6_en       (serial6_en),
        .clk_power_en     (clk_power_en),
        .stp_pullup_en    (stp_pullup_en),
        .data_pulldown_en (data_pulldown_en)
    );

    assign reg_rdata = rd_hit ? ctl_q : '0;
endmodule

// File: rtl/ifctl_chk.sv
module ifctl_chk #(
    parameter int ADDR_W    = 8,
    parameter int BASE_ADDR = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [7:0]        reg_wdata,
    input logic              exit_3pin,
    input logic              exit_6pin,
    input logic [7:0]        ctl_q,
    input logic              serial3_en,
    input logic              serial6_en,
    input logic              stp_pullup_en,
    input logic              data_pulldown_en
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] == 1'b0 && ctl_q[2] == 1'b0); // R6

    AST_EXIT3_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exit_3pin |=> !ctl_q[1]); // R7

    AST_EXIT6_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        exit_6pin |=> !ctl_q[0]); // R7

    AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(BASE_ADDR + 1) && !exit_3pin && !exit_6pin)
        |=> ctl_q == (($past(ctl_q) | $past(reg_wdata)) & 8'hEB)); // R3

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(serial3_en && serial6_en)); // R8

    AST_PROT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7] |-> (!stp_pullup_en && !data_pulldown_en)); // R11
endmodule

bind phy_ifctl ifctl_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_addr         (reg_addr),
    .reg_we           (reg_we),
    .reg_wdata        (reg_wdata),
    .exit_3pin        (exit_3pin),
    .exit_6pin        (exit_6pin),
    .ctl_q            (ctl_q),
    .serial3_en       (serial3_en),
    .serial6_en       (serial6_en),
    .stp_pullup_en    (stp_pullup_en),
    .data_pulldown_en (data_pulldown_en)
);

// File: tb/sim_phy_ifctl.sv
`timescale 1ns/1ps
module sim_phy_ifctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       exit_3pin = 1'b0, exit_6pin = 1'b0;
    logic       suspend_n = 1'b0, fault_in = 1'b0;
    logic       fault_ind_out;
    logic       stp_in = 1'b0, stp_expected = 1'b0;
    logic       serial3_en, serial6_en, clk_power_en, stp_pullup_en, data_pulldown_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    phy_ifctl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .exit_3pin(exit_3pin), .exit_6pin(exit_6pin), .suspend_n(suspend_n),
        .fault_in(fault_in), .fault_ind_out(fault_ind_out),
        .stp_in(stp_in), .stp_expected(stp_expected),
        .serial3_en(serial3_en), .serial6_en(serial6_en),
        .clk_power_en(clk_power_en), .stp_pullup_en(stp_pullup_en),
        .data_pulldown_en(data_pulldown_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic t_reset();
        fault_in = 1'b1; #1;
        rd_chk("R1 reset value", 8'h07, 8'h00);
        chk("R1 serial3", {7'd0, serial3_en}, 8'h00);
        chk("R1 serial6", {7'd0, serial6_en}, 8'h00);
        chk("R1 clk power", {7'd0, clk_power_en}, 8'h01);
        chk("R1 pullup", {7'd0, stp_pullup_en}, 8'h01);
        chk("R1 fault pass", {7'd0, fault_ind_out}, 8'h01);
        fault_in = 1'b0;
    endtask

    task automatic t_write_read();
        wr(8'h07, 8'hA5);
        rd_chk("R2 write 07", 8'h07, 8'hA1);
        rd_chk("R5 read 08", 8'h08, 8'hA1);
        rd_chk("R5 read 09", 8'h09, 8'hA1);
        rd_chk("R5 read other", 8'h0A, 8'h00);
        rd_chk("R6 reserved masked", 8'h07, 8'hA1 & 8'hEB);
        wr(8'h07, 8'h40);
        rd_chk("R12 passthru stored", 8'h07, 8'h40);
        chk("R12 no output effect", {3'd0, serial3_en, serial6_en, clk_power_en,
            stp_pullup_en, data_pulldown_en}, 8'h06);
    endtask

    task automatic t_set_clear();
        wr(8'h07, 8'h00);
        wr(8'h08, 8'h41);
        rd_chk("R3 set", 8'h07, 8'h41);
        wr(8'h08, 8'h22);
        rd_chk("R3 set accumulates", 8'h07, 8'h63);
        wr(8'h08, 8'h14);
        rd_chk("R6 set reserved ignored", 8'h07, 8'h63);
        wr(8'h09, 8'h21);
        rd_chk("R4 clear", 8'h07, 8'h42);
        wr(8'h0A, 8'hFF);
        rd_chk("R5 write elsewhere ignored", 8'h07, 8'h42);
        wr(8'h06, 8'h00);
        rd_chk("R5 write below base ignored", 8'h07, 8'h42);
    endtask

    task automatic t_modes();
        wr(8'h07, 8'h03);
        chk("R8 both set 6pin", {6'd0, serial3_en, serial6_en}, 8'h01);
        wr(8'h07, 8'h02);
        chk("R8 3pin alone", {6'd0, serial3_en, serial6_en}, 8'h02);
    endtask

    task automatic t_exit();
        wr(8'h07, 8'h03);
        @(negedge clk); exit_3pin = 1'b1;
        @(negedge clk); exit_3pin = 1'b0;
        rd_chk("R7 exit3 clears bit1", 8'h07, 8'h01);
        @(negedge clk);
        reg_addr = 8'h07; reg_wdata = 8'h03; reg_we = 1'b1; exit_6pin = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; exit_6pin = 1'b0;
        rd_chk("R7 exit6 beats write", 8'h07, 8'h02);
        @(negedge clk);
        reg_addr = 8'h08; reg_wdata = 8'h02; reg_we = 1'b1; exit_3pin = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; exit_3pin = 1'b0;
        rd_chk("R7 exit3 beats set", 8'h07, 8'h00);
    endtask

    task automatic t_fault();
        wr(8'h07, 8'h00);
        fault_in = 1'b1; #1;
        chk("R9 no invert", {7'd0, fault_ind_out}, 8'h01);
        wr(8'h08, 8'h20);
        chk("R9 invert high", {7'd0, fault_ind_out}, 8'h00);
        fault_in = 1'b0; #1;
        chk("R9 invert low", {7'd0, fault_ind_out}, 8'h01);
    endtask

    task automatic t_clock();
        wr(8'h07, 8'h01);
        suspend_n = 1'b1; #1;
        chk("R10 serial powered down", {7'd0, clk_power_en}, 8'h00);
        suspend_n = 1'b0; #1;
        chk("R10 suspend ignores bit3", {7'd0, clk_power_en}, 8'h01);
        suspend_n = 1'b1;
        wr(8'h07, 8'h09);
        chk("R10 bit3 keeps clock", {7'd0, clk_power_en}, 8'h01);
        wr(8'h07, 8'h00);
        chk("R10 no serial ignores bit3", {7'd0, clk_power_en}, 8'h01);
        wr(8'h07, 8'h02);
        chk("R10 3pin powered down", {7'd0, clk_power_en}, 8'h00);
    endtask

    task automatic t_protect();
        wr(8'h07, 8'h00);
        stp_in = 1'b1; stp_expected = 1'b0; #1;
        chk("R11 unexpected stp", {6'd0, stp_pullup_en, data_pulldown_en}, 8'h03);
        stp_expected = 1'b1; #1;
        chk("R11 expected stp", {6'd0, stp_pullup_en, data_pulldown_en}, 8'h02);
        stp_expected = 1'b0;
        wr(8'h07, 8'h80);
        chk("R11 disabled", {6'd0, stp_pullup_en, data_pulldown_en}, 8'h00);
        stp_in = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_set_clear();
        t_modes();
        t_exit();
        t_fault();
        t_clock();
        t_protect();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end
endmodule